// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences a small microcontroller between a running state and five sleep depths. Software asks for a depth with a one-cycle request and a 3-bit code. The controller then steps through a short entry window and settles in the chosen depth. From there it watches the wake events that this depth accepts. After a wake it waits a latency that grows with the depth. Then it either hands the CPU an interrupt service window or, for the two depths that drop core power, restarts the core with a reset pulse.

While the sequencer sleeps, it drives registered enables for the clock sources, the CPU, the nonvolatile memory interface, RAM and backup retention, core power, the I/O hold latch and the supply supervisor. Each enable changes on the same edge as the state change that calls for it. When the service window ends, software either returns to the depth that was left or stays running.

Mode codes on `sleep_mode` and `mode_now`:

| Code | Name |
|---|---|
| 0 | run |
| 1 | idle (CPU off) |
| 2 | standby |
| 3 | halt |
| 4 | rtc-keep (only the RTC counter runs) |
| 5 | off (shutdown) |

Top module: `power_mode_seq`

## Requirements
- R1: After reset, `mode_now` is 0, every run-mode enable of R8/R9 is 1, and `io_hold`, `core_rst` and `isr_active` are 0.
- R2: A `sleep_req` pulse is accepted only while running and only with a code from 1 to 5. Codes 0, 6 and 7 leave the block running. A request made during a service window does not change the saved depth.
- R3: On the edge that accepts a request, all enables switch to the target depth's values. Entry then lasts ENTRY_CYCLES cycles. A qualifying wake event seen during entry is kept and acted on as soon as the depth is reached.
- R4: Idle and standby wake on `irq`, `io_wake` or `rtc_wake`. Halt and off wake only on `io_wake`. Rtc-keep wakes only on `rtc_wake` or `io_wake`. Any other event leaves the depth unchanged.
- R5: Count the edges from the one that samples a wake event (inclusive) to the one that raises `cpu_en` (inclusive). The count is 1 from idle, LAT_SHORT_CYC+1 from standby and halt, and LAT_LONG_CYC+1 from rtc-keep and off.
- R6: A wake from idle, standby or halt opens a service window (`isr_active`=1, run enables). An `isr_return` pulse goes back to the saved depth with its enables, or to running when `ret_to_run` is 1.
- R7: A wake from rtc-keep or off goes straight to running with `core_rst` high for exactly one cycle.
- R8: Clocks per depth: `clk_cpu_en` only when running. `clk_sub_en`, `fast_osc_en` up to idle. `clk_aux_en` up to standby. `lfxt_en`, `lowosc_en` up to standby, plus `lfxt_en` in rtc-keep.
- R9: `nvm_pwr_en` up to idle. `ram_ret_en` and `core_pwr_en` up to halt. `bkup_ret_en` up to rtc-keep. `cpu_en` only when running.
- R10: `io_hold` is 1 in standby, halt, rtc-keep and off, and 0 otherwise.
- R11: In halt, `lfxt_en` and `lowosc_en` follow `lf_req`. In rtc-keep, `lowosc_en` follows `lf_req`. Both are sampled each cycle.
- R12: `bor_en` is always 1. `svs_en` is 1 when running or idle, and equals `svs_keep` in deeper depths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle request to sleep |
| sleep_mode | input | 3 | Requested depth code |
| irq | input | 1 | Any enabled interrupt pending |
| io_wake | input | 1 | I/O wake event |
| rtc_wake | input | 1 | RTC counter wake event |
| isr_return | input | 1 | Pulse: service routine finished |
| ret_to_run | input | 1 | On return, stay running instead of sleeping |
| lf_req | input | 1 | Low-frequency peripheral needs its slow clocks |
| svs_keep | input | 1 | Keep supply supervisor on in deep depths |
| mode_now | output | 3 | Current depth code (0 while running or servicing) |
| cpu_en | output | 1 | CPU enable |
| clk_cpu_en | output | 1 | CPU clock enable |
| clk_sub_en | output | 1 | Subsystem clock enable |
| clk_aux_en | output | 1 | Auxiliary clock enable |
| fast_osc_en | output | 1 | Fast oscillator, frequency loop and module clock enable |
| lfxt_en | output | 1 | Low-frequency crystal enable |
| lowosc_en | output | 1 | Very-low-power oscillator enable |
| nvm_pwr_en | output | 1 | Nonvolatile memory interface power |
| ram_ret_en | output | 1 | RAM retention |
| bkup_ret_en | output | 1 | Backup memory retention |
| core_pwr_en | output | 1 | Core supply enable |
| io_hold | output | 1 | I/O state-hold latch |
| svs_en | output | 1 | Supply supervisor enable |
| bor_en | output | 1 | Brownout protection enable |
| core_rst | output | 1 | One-cycle core reset after deep wake |
| isr_active | output | 1 | Service window open |

## Verification
A wrong sequencer state is visible at the ports on the edge that follows it, because every enable is a registered function of the next state. A state mix-up changes the enable pattern or `mode_now` one cycle later. A mistaken wake filter shows as `cpu_en` rising after a pulse it should have ignored. A wrong latency count shifts the `cpu_en` rise by exactly the error. A lost entry-window event keeps `cpu_en` low well past the expected latency.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic [2:0] {
        PM_RUN     = 3'd0,
        PM_IDLE    = 3'd1,
        PM_STANDBY = 3'd2,
        PM_HALT    = 3'd3,
        PM_RTCKEEP = 3'd4,
        PM_OFF     = 3'd5
    } pm_mode_e;

    typedef enum logic [2:0] {
        SQ_RUN,
        SQ_ENTER,
        SQ_SLEEP,
        SQ_WAKE,
        SQ_SERVICE
    } pm_seq_e;

    typedef enum logic [1:0] {
        LAT_NONE,
        LAT_SHORT,
        LAT_LONG
    } pm_lat_e;

    typedef struct packed {
        logic clk_cpu;
        logic clk_sub;
        logic clk_aux;
        logic fast_osc;
        logic lfxt;
        logic lowosc;
        logic cpu;
        logic nvm_pwr;
        logic ram_ret;
        logic bkup_ret;
        logic core_pwr;
        logic io_hold;
        logic svs;
        logic bor;
    } pm_en_t;

    function automatic logic code_ok(logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd5);
    endfunction

    function automatic pm_lat_e lat_class(pm_mode_e m);
        case (m)
            PM_STANDBY, PM_HALT: return LAT_SHORT;
            PM_RTCKEEP, PM_OFF:  return LAT_LONG;
            default:             return LAT_NONE;
        endcase
    endfunction

    function automatic logic loses_core(pm_mode_e m);
        return (m == PM_RTCKEEP) || (m == PM_OFF);
    endfunction

    function automatic pm_en_t mode_enables(pm_mode_e m, logic lf, logic sv);
        pm_en_t e;
        e = '0;
        e.bor = 1'b1;
        case (m)
            PM_RUN: begin
                e = '1;
                e.io_hold = 1'b0;
            end
            PM_IDLE: begin
                e = '1;
                e.io_hold = 1'b0;
                e.cpu = 1'b0;
                e.clk_cpu = 1'b0;
            end
            PM_STANDBY: begin
                e.clk_aux  = 1'b1;
                e.lfxt     = 1'b1;
                e.lowosc   = 1'b1;
                e.ram_ret  = 1'b1;
                e.bkup_ret = 1'b1;
                e.core_pwr = 1'b1;
                e.io_hold  = 1'b1;
                e.svs      = sv;
            end
            PM_HALT: begin
                e.lfxt     = lf;
                e.lowosc   = lf;
                e.ram_ret  = 1'b1;
                e.bkup_ret = 1'b1;
                e.core_pwr = 1'b1;
                e.io_hold  = 1'b1;
                e.svs      = sv;
            end
            PM_RTCKEEP: begin
                e.lfxt     = 1'b1;
                e.lowosc   = lf;
                e.bkup_ret = 1'b1;
                e.io_hold  = 1'b1;
                e.svs      = sv;
            end
            default: begin
                e.io_hold  = 1'b1;
                e.svs      = sv;
            end
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pm_wake_filter.sv
module pm_wake_filter
    import pm_pkg::*;
(
    input  pm_mode_e mode,
    input  logic     irq,
    input  logic     io_wake,
    input  logic     rtc_wake,
    output logic     wake_ok
);
    always_comb begin
        case (mode)
            PM_IDLE, PM_STANDBY: wake_ok = irq | io_wake | rtc_wake;
            PM_RTCKEEP:          wake_ok = io_wake | rtc_wake;
            PM_HALT, PM_OFF:     wake_ok = io_wake;
            default:             wake_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/pm_latency_timer.sv
module pm_latency_timer #(
    parameter int MAXV = 8400,
    localparam int CW  = $clog2(MAXV + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R5: the counter never holds more than the longest latency
    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(MAXV));
endmodule

// File: rtl/pm_enable_reg.sv
module pm_enable_reg
    import pm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     awake_d,
    input  pm_mode_e mode_d,
    input  logic     lf_req,
    input  logic     svs_keep,
    output pm_en_t   en_q,
    output pm_mode_e mode_now_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= mode_enables(PM_RUN, 1'b0, 1'b0);
            mode_now_q <= PM_RUN;
        end else begin
            en_q       <= mode_enables(awake_d ? PM_RUN : mode_d, lf_req, svs_keep);
            mode_now_q <= awake_d ? PM_RUN : mode_d;
        end
    end
endmodule

// File: rtl/power_mode_seq.sv
module power_mode_seq
    import pm_pkg::*;
#(
    parameter int ENTRY_CYCLES  = 2,
    parameter int LAT_SHORT_CYC = 240,
    parameter int LAT_LONG_CYC  = 8400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_req,
    input  logic [2:0] sleep_mode,
    input  logic       irq,
    input  logic       io_wake,
    input  logic       rtc_wake,
    input  logic       isr_return,
    input  logic       ret_to_run,
    input  logic       lf_req,
    input  logic       svs_keep,
    output logic [2:0] mode_now,
    output logic       cpu_en,
    output logic       clk_cpu_en,
    output logic       clk_sub_en,
    output logic       clk_aux_en,
    output logic       fast_osc_en,
    output logic       lfxt_en,
    output logic       lowosc_en,
    output logic       nvm_pwr_en,
    output logic       ram_ret_en,
    output logic       bkup_ret_en,
    output logic       core_pwr_en,
    output logic       io_hold,
    output logic       svs_en,
    output logic       bor_en,
    output logic       core_rst,
    output logic       isr_active
);
    localparam int MAX_A  = (ENTRY_CYCLES > LAT_SHORT_CYC) ? ENTRY_CYCLES : LAT_SHORT_CYC;
    localparam int CNT_MX = (MAX_A > LAT_LONG_CYC) ? MAX_A : LAT_LONG_CYC;
    localparam int CW     = $clog2(CNT_MX + 1);

    pm_seq_e  st_q, st_d;
    pm_mode_e mode_q, mode_d, mode_now_q;
    logic     pend_q, pend_d;
    logic     rst_pulse_q, rst_pulse_d;
    logic     svc_q;
    logic     wake_ok, t_load, t_done;
    logic [CW-1:0] t_val;
    pm_en_t   en_q;

    pm_wake_filter u_filter (
        .mode     (mode_q),
        .irq      (irq),
        .io_wake  (io_wake),
        .rtc_wake (rtc_wake),
        .wake_ok  (wake_ok)
    );

    pm_latency_timer #(.MAXV(CNT_MX)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    always_comb begin
        st_d        = st_q;
        mode_d      = mode_q;
        pend_d      = pend_q;
        rst_pulse_d = 1'b0;
        t_load      = 1'b0;
        t_val       = '0;
        case (st_q)
            SQ_RUN: begin
                if (sleep_req && code_ok(sleep_mode)) begin
                    st_d   = SQ_ENTER;
                    mode_d = pm_mode_e'(sleep_mode);
                    pend_d = 1'b0;
                    t_load = 1'b1;
                    t_val  = CW'(ENTRY_CYCLES - 1);
                end
            end
            SQ_ENTER: begin
                if (wake_ok) pend_d = 1'b1;
                if (t_done)  st_d   = SQ_SLEEP;
            end
            SQ_SLEEP: begin
                if (pend_q || wake_ok) begin
                    pend_d = 1'b0;
                    case (lat_class(mode_q))
                        LAT_SHORT: begin
                            st_d   = SQ_WAKE;
                            t_load = 1'b1;
                            t_val  = CW'(LAT_SHORT_CYC - 1);
                        end
                        LAT_LONG: begin
                            st_d   = SQ_WAKE;
                            t_load = 1'b1;
                            t_val  = CW'(LAT_LONG_CYC - 1);
                        end
                        default: st_d = SQ_SERVICE;
                    endcase
                end
            end
            SQ_WAKE: begin
                if (t_done) begin
                    if (loses_core(mode_q)) begin
                        st_d        = SQ_RUN;
                        rst_pulse_d = 1'b1;
                    end else begin
                        st_d = SQ_SERVICE;
                    end
                end
            end
            SQ_SERVICE: begin
                if (isr_return) st_d = ret_to_run ? SQ_RUN : SQ_SLEEP;
            end
            default: st_d = SQ_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= SQ_RUN;
            mode_q      <= PM_RUN;
            pend_q      <= 1'b0;
            rst_pulse_q <= 1'b0;
            svc_q       <= 1'b0;
        end else begin
            st_q        <= st_d;
            mode_q      <= mode_d;
            pend_q      <= pend_d;
            rst_pulse_q <= rst_pulse_d;
            svc_q       <= (st_d == SQ_SERVICE);
        end
    end

    pm_enable_reg u_enreg (
        .clk        (clk),
        .rst        (rst),
        .awake_d    ((st_d == SQ_RUN) || (st_d == SQ_SERVICE)),
        .mode_d     (mode_d),
        .lf_req     (lf_req),
        .svs_keep   (svs_keep),
        .en_q       (en_q),
        .mode_now_q (mode_now_q)
    );

    assign mode_now    = mode_now_q;
    assign cpu_en      = en_q.cpu;
    assign clk_cpu_en  = en_q.clk_cpu;
    assign clk_sub_en  = en_q.clk_sub;
    assign clk_aux_en  = en_q.clk_aux;
    assign fast_osc_en = en_q.fast_osc;
    assign lfxt_en     = en_q.lfxt;
    assign lowosc_en   = en_q.lowosc;
    assign nvm_pwr_en  = en_q.nvm_pwr;
    assign ram_ret_en  = en_q.ram_ret;
    assign bkup_ret_en = en_q.bkup_ret;
    assign core_pwr_en = en_q.core_pwr;
    assign io_hold     = en_q.io_hold;
    assign svs_en      = en_q.svs;
    assign bor_en      = en_q.bor;
    assign core_rst    = rst_pulse_q;
    assign isr_active  = svc_q;

    // R2: the saved depth does not move outside the running state
    assert_req_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q != SQ_RUN) |=> (mode_q == $past(mode_q)));

    // R3: an event seen during entry is kept
    assert_entry_latch_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_ENTER && wake_ok) |=> pend_q);

    // R3: a kept event leaves the sleep state at once
    assert_pend_served_R3: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_SLEEP && pend_q) |=> (st_q != SQ_SLEEP));

    // R4: halt ignores every event but I/O
    assert_halt_io_only_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_SLEEP && !pend_q && mode_q == PM_HALT && !io_wake) |=> (st_q == SQ_SLEEP));

    // R7: core reset is a single-cycle pulse
    assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> !core_rst);

    // R7: core reset comes only with the CPU back on after a deep depth
    assert_rst_deep_R7: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> (cpu_en && loses_core(mode_q)));

    // R8: CPU clock only while the CPU runs
    assert_cpuclk_R8: assert property (@(posedge clk) disable iff (rst)
        clk_cpu_en |-> (cpu_en && mode_now == 3'd0));

    // R9: no core power means nothing volatile in the core is kept
    assert_nopwr_R9: assert property (@(posedge clk) disable iff (rst)
        !core_pwr_en |-> (!ram_ret_en && !nvm_pwr_en && !cpu_en));

    // R10: held I/O never coexists with a running CPU
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        io_hold |-> !cpu_en);
endmodule

// File: tb/power_mode_seq_test.sv
module power_mode_seq_test;
    localparam int ENT = 2;
    localparam int SH  = 3;
    localparam int LG  = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_req = 1'b0;
    logic [2:0] sleep_mode = 3'd0;
    logic irq = 1'b0, io_wake = 1'b0, rtc_wake = 1'b0;
    logic isr_return = 1'b0, ret_to_run = 1'b0, lf_req = 1'b0, svs_keep = 1'b0;
    logic [2:0] mode_now;
    logic cpu_en, clk_cpu_en, clk_sub_en, clk_aux_en, fast_osc_en, lfxt_en, lowosc_en;
    logic nvm_pwr_en, ram_ret_en, bkup_ret_en, core_pwr_en, io_hold, svs_en, bor_en;
    logic core_rst, isr_active;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    power_mode_seq #(.ENTRY_CYCLES(ENT), .LAT_SHORT_CYC(SH), .LAT_LONG_CYC(LG)) uut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .sleep_mode(sleep_mode),
        .irq(irq), .io_wake(io_wake), .rtc_wake(rtc_wake), .isr_return(isr_return),
        .ret_to_run(ret_to_run), .lf_req(lf_req), .svs_keep(svs_keep),
        .mode_now(mode_now), .cpu_en(cpu_en), .clk_cpu_en(clk_cpu_en),
        .clk_sub_en(clk_sub_en), .clk_aux_en(clk_aux_en), .fast_osc_en(fast_osc_en),
        .lfxt_en(lfxt_en), .lowosc_en(lowosc_en), .nvm_pwr_en(nvm_pwr_en),
        .ram_ret_en(ram_ret_en), .bkup_ret_en(bkup_ret_en), .core_pwr_en(core_pwr_en),
        .io_hold(io_hold), .svs_en(svs_en), .bor_en(bor_en), .core_rst(core_rst),
        .isr_active(isr_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [13:0] got_en();
        return {clk_cpu_en, clk_sub_en, clk_aux_en, fast_osc_en, lfxt_en, lowosc_en, cpu_en,
                nvm_pwr_en, ram_ret_en, bkup_ret_en, core_pwr_en, io_hold, svs_en, bor_en};
    endfunction

    // expected enables from R8..R12
    function automatic logic [13:0] exp_en(input int m, input bit lf, input bit sv);
        logic cc, cs, ca, fo, lx, lo, cp, nv, ra, bk, co, ho, su;
        cc = (m == 0); cp = (m == 0);
        cs = (m <= 1); fo = (m <= 1); nv = (m <= 1);
        ca = (m <= 2);
        lx = (m <= 2) || (m == 4) || (m == 3 && lf);
        lo = (m <= 2) || ((m == 3 || m == 4) && lf);
        ra = (m <= 3); co = (m <= 3); bk = (m <= 4);
        ho = (m >= 2);
        su = (m <= 1) || sv;
        return {cc, cs, ca, fo, lx, lo, cp, nv, ra, bk, co, ho, su, 1'b1};
    endfunction

    function automatic bit qual(input int m, input int s);
        if (m == 1 || m == 2) return 1'b1;
        if (m == 4) return (s != 0);
        return (s == 1);
    endfunction

    function automatic int exp_lat(input int m);
        if (m == 1) return 1;
        if (m <= 3) return SH + 1;
        return LG + 1;
    endfunction

    task automatic request(input int m);
        sleep_mode = 3'(m);
        sleep_req = 1'b1;
        tick();
        sleep_req = 1'b0;
    endtask

    task automatic pulse_src(input int s);
        if (s == 0) irq = 1'b1;
        else if (s == 1) io_wake = 1'b1;
        else rtc_wake = 1'b1;
        tick();
        irq = 1'b0; io_wake = 1'b0; rtc_wake = 1'b0;
    endtask

    task automatic wake_measure(input int s, output int n);
        pulse_src(s);
        n = 1;
        while (!cpu_en && n < 60) begin
            tick();
            n++;
        end
    endtask

    task automatic leave_service();
        isr_return = 1'b1; ret_to_run = 1'b1;
        tick();
        isr_return = 1'b0; ret_to_run = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk(got_en() == exp_en(0, 0, 0), "R1 enables", int'(got_en()), int'(exp_en(0, 0, 0)));
        chk(mode_now == 3'd0 && !core_rst && !isr_active, "R1 mode/pulses",
            {mode_now, core_rst, isr_active}, 0);

        // R2 invalid codes ignored
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c > 5) begin
                request(c);
                tick();
                chk(mode_now == 3'd0 && cpu_en, "R2 bad code ignored", mode_now, 0);
            end
        end

        // sweep depths x sources
        for (int m = 1; m <= 5; m++) begin
            for (int s = 0; s < 3; s++) begin
                request(m);
                // R3 enables switch on the accepting edge
                chk(got_en() == exp_en(m, 0, 0), "R3/R8/R9/R10/R12 enables in entry",
                    int'(got_en()), int'(exp_en(m, 0, 0)));
                chk(mode_now == 3'(m), "R3 mode on entry", mode_now, m);
                repeat (ENT) tick();
                if (!qual(m, s)) begin
                    pulse_src(s);
                    repeat (LG + 3) tick();
                    chk(!cpu_en && mode_now == 3'(m), "R4 event ignored", cpu_en, 0);
                    wake_measure(1, n);
                end else begin
                    wake_measure(s, n);
                end
                chk(n == exp_lat(m), "R5 wake latency", n, exp_lat(m));
                if (m >= 4) begin
                    chk(core_rst && !isr_active && mode_now == 3'd0, "R7 deep wake reset",
                        core_rst, 1);
                    tick();
                    chk(!core_rst, "R7 reset one cycle", core_rst, 0);
                end else begin
                    chk(isr_active && got_en() == exp_en(0, 0, 0) && !core_rst,
                        "R6 service window", isr_active, 1);
                    if (s == 0) begin
                        isr_return = 1'b1; ret_to_run = 1'b0;
                        tick();
                        isr_return = 1'b0;
                        chk(mode_now == 3'(m) && got_en() == exp_en(m, 0, 0),
                            "R6 return to saved depth", mode_now, m);
                        wake_measure(1, n);
                        chk(n == exp_lat(m), "R5 rewake latency", n, exp_lat(m));
                    end
                    leave_service();
                    chk(mode_now == 3'd0 && cpu_en && !isr_active, "R6 return to run",
                        mode_now, 0);
                end
            end
        end

        // R3 event during entry is kept (halt, I/O)
        request(3);
        wake_measure(1, n);
        chk(n == ENT + SH + 1, "R3 latched entry event", n, ENT + SH + 1);
        leave_service();

        // R2 request during service does not overwrite saved depth
        request(1);
        repeat (ENT) tick();
        wake_measure(0, n);
        request(5);
        chk(mode_now == 3'd0 && isr_active, "R2 request in service ignored", mode_now, 0);
        isr_return = 1'b1; ret_to_run = 1'b0;
        tick();
        isr_return = 1'b0;
        chk(mode_now == 3'd1, "R2 saved depth kept", mode_now, 1);
        wake_measure(0, n);
        leave_service();

        // R11 low-frequency request in halt, tracked each cycle
        lf_req = 1'b1;
        request(3);
        chk(got_en() == exp_en(3, 1, 0), "R11 halt with lf_req", int'(got_en()),
            int'(exp_en(3, 1, 0)));
        repeat (ENT) tick();
        lf_req = 1'b0;
        tick();
        chk(got_en() == exp_en(3, 0, 0), "R11 halt lf_req dropped", int'(got_en()),
            int'(exp_en(3, 0, 0)));
        wake_measure(1, n);
        leave_service();

        // R11 rtc-keep with lf_req, R12 supervisor kept
        lf_req = 1'b1; svs_keep = 1'b1;
        request(4);
        chk(got_en() == exp_en(4, 1, 1), "R11/R12 rtc-keep lf and svs", int'(got_en()),
            int'(exp_en(4, 1, 1)));
        repeat (ENT) tick();
        wake_measure(2, n);
        lf_req = 1'b0;
        tick();

        // R12 supervisor in standby and off
        request(2);
        chk(svs_en && bor_en, "R12 standby svs_keep", svs_en, 1);
        repeat (ENT) tick();
        svs_keep = 1'b0;
        tick();
        chk(!svs_en && bor_en, "R12 standby svs off", svs_en, 0);
        wake_measure(0, n);
        leave_service();
        request(5);
        chk(got_en() == exp_en(5, 0, 0), "R12/R10 off enables", int'(got_en()),
            int'(exp_en(5, 0, 0)));
        repeat (ENT) tick();
        wake_measure(1, n);
        tick();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule